// File: doc/BRIEF.md
# Loopback-Selectable 10-bit Serializer

This block turns 10-bit encoded words into a serial bit stream, most significant bit first, advancing by one bit per bit-clock cycle or, in half-rate mode, by one bit per two bit-clock cycles. The bit clock is an ordinary input. The block counts bit clocks to find each word boundary.

At every word boundary the block raises a one-cycle strobe, `byte_tick`. The upstream encoder uses it to pace its words. The word on `word_in` is captured at the rising edge that ends the strobe cycle. The new word's first bit then appears in the very next cycle, so the stream has no gap between words.

There are two complementary output pairs: a main line pair and a loopback pair. `loop_en` chooses which pair carries data. The other pair is held at a fixed idle level, with its true line at 0 and its complement line at 1. The control is a small state machine with three states:
- `ST_IDLE`: the state after reset.
- `ST_BIT`: the first (or only) cycle of a bit slot.
- `ST_HOLD`: the second cycle of a bit slot in half-rate mode.

Its transitions are:
- `ST_IDLE`→`ST_BIT`: the first word is captured.
- `ST_BIT`→`ST_BIT`: full rate, next bit or next word.
- `ST_BIT`→`ST_HOLD`: half rate, hold the bit one more cycle.
- `ST_HOLD`→`ST_BIT`: next bit or next word.

A synchronous reset sends the machine back to `ST_IDLE` from any state.

Top module: `lbsel_serializer`

## Requirements
- R1: `word_in` is captured only at the rising edge that ends a cycle in which `byte_tick` is 1. Values on `word_in` in any other cycle have no effect on the serial output.
- R2: The captured word is sent with bit 9 first and bit 0 last.
- R3: With `loop_en` = 1, the data goes out on `lb_p`/`lb_n`, and the main pair shows `main_p` = 0, `main_n` = 1.
- R4: With `loop_en` = 0, the data goes out on `main_p`/`main_n`, and the loopback pair shows `lb_p` = 0, `lb_n` = 1.
- R5: In full-rate mode (`half_rate` = 0), each bit lasts one cycle and `byte_tick` repeats every 10 cycles.
- R6: In half-rate mode (`half_rate` = 1), each bit lasts two cycles and `byte_tick` repeats every 20 cycles.
- R7: `half_rate` is sampled together with the word. Changing it while a word is being sent does not alter that word's bit timing.
- R8: On each pair, the complement line is always the inverse of the true line.
- R9: While `rst` = 1 (synchronous, active high), `byte_tick` is 0. From the first edge under reset, both pairs are idle. In the first cycle with `rst` = 0, `byte_tick` is 1.
- R10: The first bit of a new word appears in the cycle directly after the last bit slot of the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| half_rate | input | 1 | 1 selects half-rate mode; sampled with each word |
| loop_en | input | 1 | 1 routes data to the loopback pair, 0 to the main pair |
| word_in | input | 10 | Encoded word, captured at the end of a `byte_tick` cycle |
| byte_tick | output | 1 | Word-boundary strobe, one cycle wide |
| main_p | output | 1 | Main pair, true line |
| main_n | output | 1 | Main pair, complement line |
| lb_p | output | 1 | Loopback pair, true line |
| lb_n | output | 1 | Loopback pair, complement line |

## Verification
The hardest situation to reach is a rate or loopback change that lands in the middle of a word, right at a word boundary, or just before a reset. Only then does the latching of the rate show any effect.

The stimulus re-randomises `half_rate` and `word_in` in every cycle that is not a capture cycle, so that these values act purely as noise. It flips `loop_en` at random cycles and applies a reset in the middle of the stream. A few directed words come first: all ones, all zeros, alternating bits, and the 0x0FA comma pattern, each with a fixed rate.

// File: rtl/ser_pkg.sv
package ser_pkg;
    // Controller states: idle after reset, first cycle of a bit slot,
    // second cycle of a bit slot in half-rate mode.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BIT  = 2'd1,
        ST_HOLD = 2'd2
    } ser_state_e;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
    import ser_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic half_rate,
    output logic load,
    output logic shift,
    output logic sending
);
    localparam int IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

    ser_state_e          state, nxt;
    logic [IDX_W-1:0]    bit_idx;
    logic                rate_q;
    logic                slot_end;
    logic                last_bit;

    // Slot end and strobe decode
    always_comb begin
        slot_end = ((state == ST_BIT) && !rate_q) || (state == ST_HOLD);
        last_bit = (bit_idx == LAST_IDX);
        load     = !rst && ((state == ST_IDLE) || (slot_end && last_bit));
        shift    = !rst && slot_end && !last_bit;
        sending  = (state != ST_IDLE);
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: nxt = ST_BIT;
            ST_BIT:  nxt = rate_q ? ST_HOLD : ST_BIT;
            ST_HOLD: nxt = ST_BIT;
            default: nxt = ST_IDLE;
        endcase
    end

    // State register, bit counter and latched rate
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            rate_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                bit_idx <= '0;
                rate_q  <= half_rate;
            end else if (shift) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] word_in,
    output logic              ser_bit
);
    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst)
            shreg <= '0;
        else if (load)
            shreg <= word_in;
        else if (shift)
            shreg <= {shreg[WORD_W-2:0], 1'b0};
    end

    assign ser_bit = shreg[WORD_W-1];
endmodule

// File: rtl/pair_steer.sv
module pair_steer #(
    parameter int NUM_PAIRS = 2
) (
    input  logic                 sending,
    input  logic                 loop_en,
    input  logic                 ser_bit,
    output logic [NUM_PAIRS-1:0] line_p,
    output logic [NUM_PAIRS-1:0] line_n
);
    // Pair 0 is the main line; pair 1 is the loopback path.
    for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
        logic active;
        assign active    = sending && ((g == 1) ? loop_en : !loop_en);
        assign line_p[g] = active ? ser_bit : 1'b0;
        assign line_n[g] = active ? !ser_bit : 1'b1;
    end
endmodule

// File: rtl/lbsel_serializer.sv
module lbsel_serializer #(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_rate,
    input  logic              loop_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              byte_tick,
    output logic              main_p,
    output logic              main_n,
    output logic              lb_p,
    output logic              lb_n
);
    localparam int NUM_PAIRS = 2;

    logic                 load, shift, sending, ser_bit;
    logic [NUM_PAIRS-1:0] line_p, line_n;

    ser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
        .clk(clk), .rst(rst), .half_rate(half_rate),
        .load(load), .shift(shift), .sending(sending)
    );

    ser_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst(rst), .load(load), .shift(shift),
        .word_in(word_in), .ser_bit(ser_bit)
    );

    pair_steer #(.NUM_PAIRS(NUM_PAIRS)) u_steer (
        .sending(sending), .loop_en(loop_en), .ser_bit(ser_bit),
        .line_p(line_p), .line_n(line_n)
    );

    assign byte_tick = load;
    assign main_p    = line_p[0];
    assign main_n    = line_n[0];
    assign lb_p      = line_p[1];
    assign lb_n      = line_n[1];
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         half_rate,
    input logic         loop_en,
    input logic [W-1:0] word_in,
    input logic         byte_tick,
    input logic         main_p,
    input logic         main_n,
    input logic         lb_p,
    input logic         lb_n
);
    localparam int CNT_W = $clog2(2 * W + 2);

    logic [CNT_W-1:0] cnt;
    logic             seen;
    logic             rate_l;
    logic [CNT_W-1:0] period;

    assign period = rate_l ? CNT_W'(2 * W) : CNT_W'(W);

    // Cycles since the last strobe, and the rate latched at that strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            seen   <= 1'b0;
            rate_l <= 1'b0;
        end else if (byte_tick) begin
            cnt    <= CNT_W'(1);
            seen   <= 1'b1;
            rate_l <= half_rate;
        end else if (seen) begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r8_main_complement: assert property (@(posedge clk) disable iff (rst)
        main_n == !main_p);
    a_r8_lb_complement: assert property (@(posedge clk) disable iff (rst)
        lb_n == !lb_p);
    a_r3_main_idle: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (!main_p && main_n));
    a_r4_lb_idle: assert property (@(posedge clk) disable iff (rst)
        !loop_en |-> (!lb_p && lb_n));
    a_r9_no_tick_in_reset: assert property (@(posedge clk)
        rst |-> !byte_tick);
    a_r9_tick_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> byte_tick);
    a_r5_r6_period: assert property (@(posedge clk) disable iff (rst)
        (byte_tick && seen) |-> (cnt == period));
    a_r5_r6_no_early: assert property (@(posedge clk) disable iff (rst)
        (!byte_tick && seen) |-> (cnt < period));
    a_r10_first_bit: assert property (@(posedge clk) disable iff (rst)
        byte_tick |=> ((loop_en ? lb_p : main_p) == $past(word_in[W-1])));
endmodule

bind lbsel_serializer ser_checker #(.W(WORD_W)) u_chk (
    .clk(clk), .rst(rst), .half_rate(half_rate), .loop_en(loop_en),
    .word_in(word_in), .byte_tick(byte_tick), .main_p(main_p),
    .main_n(main_n), .lb_p(lb_p), .lb_n(lb_n)
);

// File: tb/test_lbsel_serializer.sv
module test_lbsel_serializer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       half_rate = 1'b0;
    logic       loop_en = 1'b0;
    logic [9:0] word_in = '0;
    logic       byte_tick, main_p, main_n, lb_p, lb_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    bit         started = 0;
    logic [9:0] wm = '0;
    bit         hm = 0;
    int         pos = 0;
    int         fidx = 0;
    logic [9:0] forced_w [4] = '{10'h3FF, 10'h000, 10'h155, 10'h0FA};
    bit         forced_h [4] = '{1'b0, 1'b1, 1'b0, 1'b1};

    lbsel_serializer i_lbsel_serializer (
        .clk(clk), .rst(rst), .half_rate(half_rate), .loop_en(loop_en),
        .word_in(word_in), .byte_tick(byte_tick), .main_p(main_p),
        .main_n(main_n), .lb_p(lb_p), .lb_n(lb_n)
    );

    always #4 clk = ~clk;

    function automatic int period_of(bit h);
        return h ? 20 : 10;
    endfunction

    function automatic logic exp_bit(logic [9:0] w, bit h, int p);
        return w[9 - (p / (h ? 2 : 1))];
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    task automatic check_idle(string tag);
        chk(main_p == 1'b0 && main_n == 1'b1, tag, {main_p, main_n}, 2'b01);
        chk(lb_p == 1'b0 && lb_n == 1'b1, tag, {lb_p, lb_n}, 2'b01);
    endtask

    // Check outputs against the model, then drive the next inputs.
    task automatic body();
        bit   exp_tick;
        logic eb;
        if (rst) begin
            chk(byte_tick == 1'b0, "R9 tick in reset", byte_tick, 0);
            check_idle("R9 idle in reset");
            return;
        end
        exp_tick = !started || (pos == period_of(hm) - 1);
        chk(byte_tick == exp_tick, "R5/R6 tick timing", byte_tick, exp_tick);
        if (!started) begin
            check_idle("R9 idle before first word");
        end else begin
            // R2, R10: bit order and gapless word sequence
            eb = exp_bit(wm, hm, pos);
            if (loop_en) begin
                chk(lb_p == eb, "R3 R2 loopback data", lb_p, eb);
                chk(lb_n == !eb, "R8 loopback complement", lb_n, !eb);
                chk(!main_p && main_n, "R3 main idle", {main_p, main_n}, 2'b01);
            end else begin
                chk(main_p == eb, "R4 R2 main data", main_p, eb);
                chk(main_n == !eb, "R8 main complement", main_n, !eb);
                chk(!lb_p && lb_n, "R4 loopback idle", {lb_p, lb_n}, 2'b01);
            end
        end
        if (exp_tick) begin
            if (fidx < 4) begin
                word_in   = forced_w[fidx];
                half_rate = forced_h[fidx];
                fidx++;
            end else begin
                word_in   = 10'($urandom);
                half_rate = 1'($urandom);
            end
            wm = word_in;
            hm = half_rate;
            pos = 0;
            started = 1;
        end else begin
            pos++;
            // R1, R7: noise outside capture cycles must not matter
            word_in   = 10'($urandom);
            half_rate = 1'($urandom);
        end
        if (($urandom % 8) == 0) loop_en = !loop_en;
    endtask

    task automatic step();
        @(negedge clk);
        body();
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst = 1'b0;
        #1;
        body();  // R9: strobe in first cycle out of reset
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        started = 0;
        for (int i = 0; i < 3; i++) step();
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        for (int i = 0; i < 3; i++) step();
        release_reset();
        for (int i = 0; i < 700; i++) step();
        apply_reset();
        release_reset();
        for (int i = 0; i < 700; i++) step();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule